// File: doc/BRIEF.md
# Quadrature Encoder Step Decoder

This block turns two phase signals from a rotary or linear encoder into step commands for a position counter. Every cycle it reports whether the counter should move, and in which direction. It also keeps a flag that holds the direction of the most recent step. Each phase first passes through a selectable inversion and a two-stage synchronizer. It then passes through its own digital glitch filter. The filter passes a new level only once that level has been held for a programmed number of clocks. A filter value of zero bypasses the filter.

Two encodings are supported. In quadrature mode, every valid edge on either phase is one step. The direction comes from the order in which the phases change. In count-and-direction mode, phase A acts as a step strobe and phase B gives the direction. All settings for phase A and phase B are separate ports and can differ freely.

Top module: `quad_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cnt_en`, `cnt_up` and `dir_flag` are 0. The filtered phase levels start at logic low.
- R2: With a filter value of 0, a phase change at the pins shows on `cnt_en` four clock edges later: two synchronizer stages, one filter register and one output register.
- R3: With a filter value N ≥ 1, a new level is passed only after the synchronized input has differed from the filtered level for N consecutive clocks. The latency to `cnt_en` is 3+N edges. A pulse shorter than N clocks produces no step.
- R4: In quadrature mode (`mode`=0), each change of exactly one filtered phase gives one `cnt_en` pulse. The step is up when new A differs from old B. The logical (A,B) sequence 00→10→11→01→00 counts up, and the reverse counts down.
- R5: In quadrature mode, a transition in which both filtered phases change in the same cycle gives no step.
- R6: In count-and-direction mode (`mode`=1), only a rising edge of logical phase A gives a step. The step is up when logical B is 1. Falling A edges and any B change give no step.
- R7: When `inv_a` or `inv_b` is 1, the corresponding pin is inverted before all other processing. Each setting is independent of the other.
- R8: `cnt_up` is 1 only together with `cnt_en`. `dir_flag` takes the value of `cnt_up` on every step and holds it while no step occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = quadrature, 1 = count-and-direction |
| inv_a | input | 1 | Invert phase A pin |
| inv_b | input | 1 | Invert phase B pin |
| filt_a | input | FILT_W | Phase A filter length in clocks, 0 = off |
| filt_b | input | FILT_W | Phase B filter length in clocks, 0 = off |
| ph_a | input | 1 | Phase A pin (asynchronous) |
| ph_b | input | 1 | Phase B pin (asynchronous) |
| cnt_en | output | 1 | Step the counter this cycle |
| cnt_up | output | 1 | Step direction, 1 = up, valid with `cnt_en` |
| dir_flag | output | 1 | Direction of the last step |

## Verification
The bench builds the block with `FILT_W` = 4. This makes the full filter range, from 0 up to the maximum of 15, cheap to reach in both the directed latency checks and the random walks. Because the filter range is short, random walks can use a hold time longer than the worst filter. They can also inject sub-threshold glitches on phase A, and still keep the expected step counts exact. The directed cases pin down the edge-exact latency at filter values 0, 1, 3, 15 and 5 (the last on phase B).

// File: rtl/qd_pkg.sv
package qd_pkg;

    typedef enum logic {
        QD_QUAD   = 1'b0,
        QD_CNTDIR = 1'b1
    } qd_mode_e;

    typedef struct packed {
        logic a;
        logic b;
    } qd_lvl_t;

    typedef struct packed {
        logic en;
        logic up;
    } qd_step_t;

    // Gray-code step: one phase moved; up when new A differs from old B.
    function automatic qd_step_t quad_step(qd_lvl_t prev, qd_lvl_t cur);
        qd_step_t s;
        s.en = (prev.a ^ cur.a) ^ (prev.b ^ cur.b);
        s.up = s.en & (cur.a ^ prev.b);
        return s;
    endfunction

    // Strobe on rising A, direction from B.
    function automatic qd_step_t cntdir_step(qd_lvl_t prev, qd_lvl_t cur);
        qd_step_t s;
        s.en = cur.a & ~prev.a;
        s.up = s.en & cur.b;
        return s;
    endfunction

endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/qd_filter.sv
module qd_filter #(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [FILT_W-1:0] limit,
    output logic              q
);
    localparam logic [FILT_W-1:0] ONE = FILT_W'(1);

    logic [FILT_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            run <= '0;
        end else if (limit == '0) begin
            q   <= din;
            run <= '0;
        end else if (din == q) begin
            run <= '0;
        end else if (run == limit - ONE) begin
            q   <= din;
            run <= '0;
        end else begin
            run <= run + ONE;
        end
    end

    AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> ($past(din) == q)); // R3
endmodule

// File: rtl/qd_step.sv
module qd_step
    import qd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  qd_mode_e mode,
    input  qd_lvl_t  cur,
    output logic     en,
    output logic     up,
    output logic     dir
);
    qd_lvl_t  prev;
    qd_step_t nxt;

    always_comb begin
        if (mode == QD_QUAD) nxt = quad_step(prev, cur);
        else                 nxt = cntdir_step(prev, cur);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            en   <= 1'b0;
            up   <= 1'b0;
            dir  <= 1'b0;
        end else begin
            prev <= cur;
            en   <= nxt.en;
            up   <= nxt.up;
            if (nxt.en) dir <= nxt.up;
        end
    end

    AST_NO_DOUBLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == QD_QUAD && cur.a != prev.a && cur.b != prev.b) |=> !en); // R5
    AST_CD_FALL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mode == QD_CNTDIR && prev.a && !cur.a) |=> !en); // R6
    AST_CD_B_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mode == QD_CNTDIR && cur.a == prev.a) |=> !en); // R6
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
    import qd_pkg::*;
#(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic              inv_a,
    input  logic              inv_b,
    input  logic [FILT_W-1:0] filt_a,
    input  logic [FILT_W-1:0] filt_b,
    input  logic              ph_a,
    input  logic              ph_b,
    output logic              cnt_en,
    output logic              cnt_up,
    output logic              dir_flag
);
    localparam int NPH = 2;

    logic [NPH-1:0]    pin_lvl;
    logic [NPH-1:0]    sync_lvl;
    logic [NPH-1:0]    filt_lvl;
    logic [FILT_W-1:0] limit [NPH];
    qd_lvl_t           cur;

    assign pin_lvl  = {ph_b ^ inv_b, ph_a ^ inv_a};
    assign limit[0] = filt_a;
    assign limit[1] = filt_b;

    qd_sync #(.WIDTH(NPH), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_lvl),
        .dout (sync_lvl)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        qd_filter #(.FILT_W(FILT_W)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .din   (sync_lvl[i]),
            .limit (limit[i]),
            .q     (filt_lvl[i])
        );
    end

    assign cur.a = filt_lvl[0];
    assign cur.b = filt_lvl[1];

    qd_step u_step (
        .clk  (clk),
        .rst  (rst),
        .mode (qd_mode_e'(mode)),
        .cur  (cur),
        .en   (cnt_en),
        .up   (cnt_up),
        .dir  (dir_flag)
    );

    AST_UP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        cnt_up |-> cnt_en); // R8
    AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |-> $stable(dir_flag)); // R8
    AST_DIR_TRACKS: assert property (@(posedge clk) disable iff (rst)
        cnt_en |-> (dir_flag == cnt_up)); // R8
endmodule

// File: tb/quad_decoder_test.sv
module quad_decoder_test;
    localparam int FW = 4;

    logic clk = 1'b0, rst = 1'b1, mode = 1'b0;
    logic inv_a = 1'b0, inv_b = 1'b0, ph_a = 1'b0, ph_b = 1'b0;
    logic [FW-1:0] filt_a = '0, filt_b = '0;
    logic cnt_en, cnt_up, dir_flag;

    int n_chk = 0, n_bad = 0;
    int n_up = 0, n_dn = 0, n_orphan = 0;
    bit la = 0, lb = 0;
    bit done = 0;

    always #2 clk = ~clk;

    quad_decoder #(.FILT_W(FW)) uut (
        .clk(clk), .rst(rst), .mode(mode), .inv_a(inv_a), .inv_b(inv_b),
        .filt_a(filt_a), .filt_b(filt_b), .ph_a(ph_a), .ph_b(ph_b),
        .cnt_en(cnt_en), .cnt_up(cnt_up), .dir_flag(dir_flag)
    );

    always @(posedge clk) begin
        #1;
        if (rst) begin
            n_up = 0;
            n_dn = 0;
        end else if (cnt_en) begin
            if (cnt_up) n_up++;
            else n_dn++;
        end else if (cnt_up) begin
            n_orphan++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit a, input bit b);
        la = a;
        lb = b;
        ph_a = a ^ inv_a;
        ph_b = b ^ inv_b;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input bit m, input bit ia, input bit ib, input int fa, input int fb);
        @(negedge clk);
        rst = 1'b1;
        mode = m;
        inv_a = ia;
        inv_b = ib;
        filt_a = FW'(fa);
        filt_b = FW'(fb);
        drive(0, 0);
        hold(3);
        rst = 1'b0;
    endtask

    function automatic int lat_of(input int n);
        return 3 + ((n == 0) ? 1 : n);
    endfunction

    // R2 / R3: edge-exact latency of a single phase A rise (up step)
    task automatic lat_a(input int n);
        int l;
        start(0, 0, 0, n, 0);
        drive(1, 0);
        l = lat_of(n);
        hold(l - 1);
        chk((n == 0) ? "R2 early" : "R3 early", cnt_en, 0);
        hold(1);
        chk((n == 0) ? "R2 step" : "R3 step", cnt_en, 1);
        chk("R4 up on A lead", cnt_up, 1);
        chk("R8 dir after up", dir_flag, 1);
    endtask

    function automatic bit st_a(input int s);
        return (s == 1) || (s == 2);
    endfunction
    function automatic bit st_b(input int s);
        return (s == 2) || (s == 3);
    endfunction

    task automatic random_walk();
        int s, hl, eu, ed, fa, fb;
        bit up;
        fa = $urandom % 16;
        fb = $urandom % 16;
        start(0, 1'($urandom % 2), 1'($urandom % 2), fa, fb);
        hl = ((fa > fb) ? fa : fb) + 6;
        s = 0; eu = 0; ed = 0;
        for (int k = 1; k <= 120; k++) begin
            up = 1'($urandom % 2);
            s = up ? (s + 1) % 4 : (s + 3) % 4;
            if (up) eu++;
            else ed++;
            drive(st_a(s), st_b(s));
            hold(hl);
            if (fa >= 2 && ($urandom % 4) == 0) begin
                drive(!st_a(s), st_b(s));
                hold(fa - 1);
                drive(st_a(s), st_b(s));
                hold(hl);
            end
            if (k % 20 == 0) begin
                chk("R4 random up count", n_up, eu);
                chk("R4 random down count", n_dn, ed);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        ph_a = 1'b1;
        ph_b = 1'b1;
        hold(3);
        chk("R1 en in reset", cnt_en, 0);
        chk("R1 up in reset", cnt_up, 0);
        chk("R1 dir in reset", dir_flag, 0);
        rst = 1'b0;
        drive(0, 0);
        @(negedge clk);
        chk("R1 en after reset", cnt_en, 0);
        chk("R1 dir after reset", dir_flag, 0);

        lat_a(0);
        lat_a(1);
        lat_a(3);
        lat_a(15);

        // R3 phase B has its own filter; 00->01 is a down step
        start(0, 0, 0, 0, 5);
        drive(0, 1);
        hold(lat_of(5) - 1);
        chk("R3 B early", cnt_en, 0);
        hold(1);
        chk("R3 B step", cnt_en, 1);
        chk("R4 down on B lead", cnt_up, 0);
        chk("R8 dir after down", dir_flag, 0);

        // R3 glitch rejection and acceptance at exactly N
        start(0, 0, 0, 4, 0);
        drive(1, 0); hold(3); drive(0, 0); hold(20);
        chk("R3 short pulse rejected", n_up + n_dn, 0);
        drive(1, 0); hold(4); drive(0, 0); hold(20);
        chk("R3 pulse of N passes up", n_up, 1);
        chk("R3 pulse of N passes down", n_dn, 1);

        // R5 both phases together
        start(0, 0, 0, 0, 0);
        drive(1, 1); hold(10);
        chk("R5 double change ignored", n_up + n_dn, 0);
        drive(0, 1); hold(10);
        chk("R5 state kept after illegal", n_up, 1);
        chk("R8 dir held", dir_flag, 1);
        hold(10);
        chk("R8 dir still held", dir_flag, 1);

        // R6 count and direction
        start(1, 0, 0, 0, 0);
        drive(0, 1); hold(10);
        chk("R6 B change ignored", n_up + n_dn, 0);
        drive(1, 1); hold(10);
        chk("R6 rise A with B high", n_up, 1);
        drive(0, 1); hold(10);
        chk("R6 fall A ignored", n_up + n_dn, 1);
        drive(0, 0); hold(10);
        drive(1, 0); hold(10);
        chk("R6 rise A with B low", n_dn, 1);
        chk("R8 dir down", dir_flag, 0);

        // R7 inversion
        start(1, 1, 1, 0, 0);
        drive(0, 1); hold(10);
        drive(1, 1); hold(10);
        chk("R7 inverted pins step up", n_up, 1);
        chk("R7 inverted total", n_up + n_dn, 1);
        start(0, 1, 0, 0, 0);
        drive(1, 0); hold(10);
        chk("R7 invert A only up", n_up, 1);
        chk("R7 invert A only no down", n_dn, 0);

        for (int r = 0; r < 3; r++) random_walk();

        chk("R8 up without en", n_orphan, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule